// File: doc/BRIEF.md
# Received-Message Queue with Fill-Level Interrupt

This block is the receive-side message queue of a CAN-style controller. The receive path hands it complete messages one at a time. The host pops them in arrival order. A control word sets four things: the capacity (none, 4, 8 or 16 messages), whether storage is in use, whether the interrupt line may fire, and which event raises it. The event is either the fill count reaching a programmable fraction of the capacity, counted in eighths, or every stored message.

The capacity, the interrupt source and the threshold fraction may only change while the controller-wide reset mode input is high. While that input is high, the queue is flushed and new messages are not stored. The two enable bits may be written at any time. A message that arrives while the queue is full is dropped, and a sticky overflow flag records it. A pop from an empty queue is answered with no valid data.

Top module: `rx_msg_fifo`

## Requirements
- R1: After a synchronous reset, the control word reads 0, the fill count is 0, and the interrupt, overflow and pop-valid outputs are 0.
- R2: The control word layout is: bit 0 store enable, bit 1 interrupt enable, bits 4:2 capacity code, bit 5 every-message mode, bits 8:6 threshold code. Bits 15:9 always read 0, and writing 1s to them has no effect.
- R3: Writes to bits 8:2 take effect only while `cfg_mode_i` is 1; at other times those bits keep their value while bits 1:0 still update. While `cfg_mode_i` is 1, the queue is emptied and the overflow flag clears.
- R4: Capacity code 000 gives 0 messages, 001 gives 4, 010 gives 8 and 011 gives 16; codes 100 to 111 give 0. With zero capacity, or with store enable at 0, messages are not stored, the fill count stays 0 and no interrupt is raised.
- R5: Messages are popped oldest first, including after the storage pointers wrap. A pop that is accepted raises `pop_valid_o` for one cycle on the next clock edge, with the message on `pop_data_o`, and lowers the fill count by one.
- R6: The threshold level is ceil((k+1)*D/8) for threshold code k and capacity D. With capacity 4, codes 000 and 001 give 1 message, 010 and 011 give 2, 100 and 101 give 3, and 110 and 111 give 4. Code 111 gives a full queue for every capacity.
- R7: In threshold mode (bit 5 = 0), `irq_o` is a one-cycle pulse on the edge after a stored message raises the fill count from level-1 to the threshold level.
- R8: In every-message mode (bit 5 = 1), `irq_o` pulses once on the edge after each stored message.
- R9: While interrupt enable (bit 1) is 0, `irq_o` stays 0.
- R10: A message that arrives while the queue is full is discarded, the count is unchanged and `ovf_o` becomes 1 and stays 1 until R3 clears it. A pop from an empty queue leaves the count unchanged and `pop_valid_o` at 0.
- R11: A message store and a pop in the same cycle, on a queue that is neither empty nor full, leave the count unchanged and raise no threshold-mode interrupt. In every-message mode, the interrupt still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode_i | input | 1 | Controller-wide reset mode; unlocks configuration and flushes the queue |
| reg_we_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 16 | Control word write data |
| reg_rdata_o | output | 16 | Control word read-back |
| msg_valid_i | input | 1 | A received message is presented |
| msg_data_i | input | MSG_W | Received message contents |
| pop_i | input | 1 | Host pops the oldest message |
| pop_data_o | output | MSG_W | Popped message, meaningful with pop_valid_o |
| pop_valid_o | output | 1 | Pop result is valid (one cycle) |
| fill_o | output | 5 | Number of stored messages |
| irq_o | output | 1 | Interrupt request pulse |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A message store and a host pop can fall in the same cycle. This matters most when the count is one below the threshold level, where a store alone would fire the interrupt. The bench sets up exactly that case in the vector table (count 2 against level 3). It presents a message and a pop together and expects the count to hold, no interrupt pulse, and the oldest message on the pop port. The same pairing is then repeated in every-message mode, where the pulse is expected. A third pairing on an empty queue is expected to store the message and reject the pop.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int REG_W    = 16;
  localparam int CTRL_W   = 9;
  localparam int MAX_MSGS = 16;
  localparam int CNT_W    = $clog2(MAX_MSGS) + 1;
  localparam int PTR_W    = $clog2(MAX_MSGS);

  typedef struct packed {
    logic [2:0] thr;
    logic       every;
    logic [2:0] depth;
    logic       irq_en;
    logic       buf_en;
  } rxf_ctrl_t;

  function automatic logic [CNT_W-1:0] rxf_cap(input logic [2:0] dcode);
    case (dcode)
      3'b001:  return CNT_W'(4);
      3'b010:  return CNT_W'(8);
      3'b011:  return CNT_W'(16);
      default: return '0;
    endcase
  endfunction

  // ceil((k+1) * capacity / 8)
  function automatic logic [CNT_W-1:0] rxf_level(input logic [2:0] dcode,
                                                 input logic [2:0] tcode);
    logic [8:0] prod;
    prod = {{(9-CNT_W){1'b0}}, rxf_cap(dcode)} * ({6'd0, tcode} + 9'd1);
    prod = prod + 9'd7;
    return CNT_W'(prod >> 3);
  endfunction
endpackage

// File: rtl/rxf_ctrl_regs.sv
module rxf_ctrl_regs
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_mode_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output rxf_ctrl_t        ctrl_o,
  output logic [REG_W-1:0] rdata_o
);
  rxf_ctrl_t ctrl_q;
  rxf_ctrl_t wr_view;
  logic      unused_rsv;

  assign wr_view    = rxf_ctrl_t'(wdata_i[CTRL_W-1:0]);
  assign unused_rsv = ^wdata_i[REG_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      ctrl_q.buf_en <= wr_view.buf_en;
      ctrl_q.irq_en <= wr_view.irq_en;
      if (cfg_mode_i) begin
        ctrl_q.depth <= wr_view.depth;
        ctrl_q.every <= wr_view.every;
        ctrl_q.thr   <= wr_view.thr;
      end
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
endmodule

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int MSG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic [CNT_W-1:0] cap_i,
  input  logic             wr_i,
  input  logic [MSG_W-1:0] wdata_i,
  input  logic             rd_i,
  output logic [MSG_W-1:0] rdata_o,
  output logic             rvalid_o,
  output logic [CNT_W-1:0] count_o,
  output logic             wr_acc_o,
  output logic             rd_acc_o,
  output logic             ovf_o
);
  logic [MSG_W-1:0] mem [MAX_MSGS];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, empty, wr_acc, rd_acc;
  logic             ovf_q, rv_q;

  assign full   = (cnt_q >= cap_i);
  assign empty  = (cnt_q == '0);
  assign wr_acc = active_i & wr_i & ~full;
  assign rd_acc = active_i & rd_i & ~empty;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                            input logic [CNT_W-1:0] lim);
    if (({1'b0, p} + CNT_W'(1)) == lim) return '0;
    return p + PTR_W'(1);
  endfunction

  // storage without reset so it can map to block RAM
  always_ff @(posedge clk) begin
    if (wr_acc) mem[wp_q] <= wdata_i;
    if (rd_acc) rdata_o <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      rv_q  <= 1'b0;
    end else begin
      rv_q <= rd_acc;
      if (!active_i) begin
        wp_q  <= '0;
        rp_q  <= '0;
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end else begin
        if (wr_acc) wp_q <= bump(wp_q, cap_i);
        if (rd_acc) rp_q <= bump(rp_q, cap_i);
        case ({wr_acc, rd_acc})
          2'b10:   cnt_q <= cnt_q + CNT_W'(1);
          2'b01:   cnt_q <= cnt_q - CNT_W'(1);
          default: cnt_q <= cnt_q;
        endcase
        if (wr_i && full) ovf_q <= 1'b1;
      end
    end
  end

  assign rvalid_o = rv_q;
  assign count_o  = cnt_q;
  assign wr_acc_o = wr_acc;
  assign rd_acc_o = rd_acc;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/rxf_irq_gen.sv
module rxf_irq_gen
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  rxf_ctrl_t        ctrl_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wr_acc_i,
  input  logic             rd_acc_i,
  output logic             irq_o
);
  logic [CNT_W-1:0] level;
  logic             hit;
  logic             irq_q;

  assign level = rxf_level(ctrl_i.depth, ctrl_i.thr);
  assign hit   = wr_acc_i & ~rd_acc_i & ((count_i + CNT_W'(1)) == level);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ctrl_i.irq_en & (ctrl_i.every ? wr_acc_i : hit);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo
  import rxf_pkg::*;
#(
  parameter int MSG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_mode_i,
  input  logic             reg_we_i,
  input  logic [15:0]      reg_wdata_i,
  output logic [15:0]      reg_rdata_o,
  input  logic             msg_valid_i,
  input  logic [MSG_W-1:0] msg_data_i,
  input  logic             pop_i,
  output logic [MSG_W-1:0] pop_data_o,
  output logic             pop_valid_o,
  output logic [4:0]       fill_o,
  output logic             irq_o,
  output logic             ovf_o
);
  rxf_ctrl_t        ctrl;
  logic [CNT_W-1:0] cap;
  logic [CNT_W-1:0] count;
  logic             active, wr_acc, rd_acc;

  rxf_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .cfg_mode_i(cfg_mode_i),
    .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .ctrl_o(ctrl), .rdata_o(reg_rdata_o)
  );

  assign cap    = rxf_cap(ctrl.depth);
  assign active = ctrl.buf_en & ~cfg_mode_i & (cap != '0);

  rxf_store #(.MSG_W(MSG_W)) u_store (
    .clk(clk), .rst(rst), .active_i(active), .cap_i(cap),
    .wr_i(msg_valid_i), .wdata_i(msg_data_i), .rd_i(pop_i),
    .rdata_o(pop_data_o), .rvalid_o(pop_valid_o), .count_o(count),
    .wr_acc_o(wr_acc), .rd_acc_o(rd_acc), .ovf_o(ovf_o)
  );

  rxf_irq_gen u_irq (
    .clk(clk), .rst(rst), .ctrl_i(ctrl), .count_i(count),
    .wr_acc_i(wr_acc), .rd_acc_i(rd_acc), .irq_o(irq_o)
  );

  assign fill_o = count;
endmodule

// File: rtl/rx_msg_fifo_chk.sv
module rx_msg_fifo_chk
  import rxf_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        cfg_mode_i,
  input logic [15:0] reg_rdata_o,
  input logic [4:0]  fill_o,
  input logic        irq_o,
  input logic        ovf_o,
  input logic        pop_valid_o
);
  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata_o[15:9] == 7'd0);

  // R3
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_mode_i) |-> reg_rdata_o[8:2] == $past(reg_rdata_o[8:2]));

  // R4
  fill_cap_chk: assert property (@(posedge clk) disable iff (rst)
    fill_o <= rxf_cap(reg_rdata_o[4:2]));

  // R5
  fill_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_o != $past(fill_o)) |->
      (fill_o == 5'($past(fill_o) + 5'd1)) ||
      (fill_o == 5'($past(fill_o) - 5'd1)) || (fill_o == 5'd0));

  // R7
  thr_level_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !reg_rdata_o[5]) |->
      fill_o == rxf_level(reg_rdata_o[4:2], reg_rdata_o[8:6]));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(reg_rdata_o[1]));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !cfg_mode_i && reg_rdata_o[0] &&
     (rxf_cap(reg_rdata_o[4:2]) != 5'd0)) |=> ovf_o);

  // R10
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    pop_valid_o |-> $past(fill_o) != 5'd0);
endmodule

bind rx_msg_fifo rx_msg_fifo_chk u_chk (
  .clk(clk), .rst(rst), .cfg_mode_i(cfg_mode_i), .reg_rdata_o(reg_rdata_o),
  .fill_o(fill_o), .irq_o(irq_o), .ovf_o(ovf_o), .pop_valid_o(pop_valid_o)
);

// File: tb/tb_rx_msg_fifo.sv
module tb_rx_msg_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 8;
  localparam int NV = 20;

  // {wr, rd, data, exp_fill, exp_irq, exp_rv, exp_rdata, exp_ovf}
  localparam bit [25:0] VEC [NV] = '{
    {1'b1,1'b0,8'h11,5'd1,1'b0,1'b0,8'h00,1'b0},
    {1'b1,1'b0,8'h22,5'd2,1'b0,1'b0,8'h00,1'b0},
    {1'b1,1'b0,8'h33,5'd3,1'b1,1'b0,8'h00,1'b0},
    {1'b0,1'b1,8'h00,5'd2,1'b0,1'b1,8'h11,1'b0},
    {1'b1,1'b1,8'h44,5'd2,1'b0,1'b1,8'h22,1'b0},
    {1'b1,1'b0,8'h55,5'd3,1'b1,1'b0,8'h00,1'b0},
    {1'b0,1'b1,8'h00,5'd2,1'b0,1'b1,8'h33,1'b0},
    {1'b0,1'b1,8'h00,5'd1,1'b0,1'b1,8'h44,1'b0},
    {1'b0,1'b1,8'h00,5'd0,1'b0,1'b1,8'h55,1'b0},
    {1'b0,1'b1,8'h00,5'd0,1'b0,1'b0,8'h00,1'b0},
    {1'b1,1'b1,8'h66,5'd1,1'b0,1'b0,8'h00,1'b0},
    {1'b1,1'b0,8'h70,5'd2,1'b0,1'b0,8'h00,1'b0},
    {1'b1,1'b0,8'h71,5'd3,1'b1,1'b0,8'h00,1'b0},
    {1'b1,1'b0,8'h72,5'd4,1'b0,1'b0,8'h00,1'b0},
    {1'b1,1'b0,8'h73,5'd5,1'b0,1'b0,8'h00,1'b0},
    {1'b1,1'b0,8'h74,5'd6,1'b0,1'b0,8'h00,1'b0},
    {1'b1,1'b0,8'h75,5'd7,1'b0,1'b0,8'h00,1'b0},
    {1'b1,1'b0,8'h76,5'd8,1'b0,1'b0,8'h00,1'b0},
    {1'b1,1'b0,8'h99,5'd8,1'b0,1'b0,8'h00,1'b1},
    {1'b0,1'b1,8'h00,5'd7,1'b0,1'b1,8'h66,1'b1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_mode = 1'b0;
  logic          reg_we = 1'b0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic          msg_valid = 1'b0;
  logic [MW-1:0] msg_data = '0;
  logic          pop = 1'b0;
  logic [MW-1:0] pop_data;
  logic          pop_valid;
  logic [4:0]    fill;
  logic          irq, ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_msg_fifo #(.MSG_W(MW)) dut (
    .clk(clk), .rst(rst), .cfg_mode_i(cfg_mode), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .msg_valid_i(msg_valid), .msg_data_i(msg_data), .pop_i(pop),
    .pop_data_o(pop_data), .pop_valid_o(pop_valid), .fill_o(fill),
    .irq_o(irq), .ovf_o(ovf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // drive at negedge, let one edge pass, return at the following negedge
  task automatic step(input logic wr, input logic [MW-1:0] d, input logic rd);
    msg_valid = wr; msg_data = d; pop = rd;
    @(posedge clk); @(negedge clk);
    msg_valid = 1'b0; pop = 1'b0;
  endtask

  task automatic wreg(input logic [15:0] v);
    reg_we = 1'b1; reg_wdata = v;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic configure(input logic [15:0] v);
    cfg_mode = 1'b1;
    wreg(v);
    cfg_mode = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", 32'(reg_rdata), 32'h0);
    chk("R1 fill", 32'(fill), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 ovf", 32'(ovf), 0);
    chk("R1 pop_valid", 32'(pop_valid), 0);

    // R2 / R3 field handling
    configure(16'hFFFF);
    chk("R2 reserved read 0", 32'(reg_rdata), 32'h01FF);
    configure(16'h008B);  // cap 8, threshold code 010 (level 3), enables on
    chk("R3 cfg write", 32'(reg_rdata), 32'h008B);
    wreg(16'h0000);
    chk("R3 locked fields kept", 32'(reg_rdata), 32'h0088);
    wreg(16'hFFFF);
    chk("R3 enables only", 32'(reg_rdata), 32'h008B);

    // vector table: R5 R6 R7 R10 R11
    for (int i = 0; i < NV; i++) begin
      bit [25:0] v;
      v = VEC[i];
      step(v[25], v[23:16], v[24]);
      chk($sformatf("R5 fill v%0d", i), 32'(fill), 32'(v[15:11]));
      chk($sformatf("R7/R11 irq v%0d", i), 32'(irq), 32'(v[10]));
      chk($sformatf("R10 pop_valid v%0d", i), 32'(pop_valid), 32'(v[9]));
      if (v[9]) chk($sformatf("R5 pop_data v%0d", i), 32'(pop_data), 32'(v[8:1]));
      chk($sformatf("R10 ovf v%0d", i), 32'(ovf), 32'(v[0]));
    end
    // drain after pointer wrap: R5
    for (int j = 0; j < 7; j++) begin
      step(1'b0, '0, 1'b1);
      chk("R5 drain order", 32'(pop_data), 32'(8'h70 + j));
      chk("R5 drain fill", 32'(fill), 32'(6 - j));
    end
    chk("R10 ovf sticky", 32'(ovf), 1);
    step(1'b1, 8'hA0, 1'b0);
    cfg_mode = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R3 flush fill", 32'(fill), 0);
    chk("R3 ovf cleared", 32'(ovf), 0);
    cfg_mode = 1'b0;

    // R6 rounding, capacity 4, threshold code 010 -> level 2
    configure(16'h0087);
    step(1'b1, 8'h01, 1'b0); chk("R6 c4 k2 w1 irq", 32'(irq), 0);
    step(1'b1, 8'h02, 1'b0); chk("R6 c4 k2 w2 irq", 32'(irq), 1);
    step(1'b1, 8'h03, 1'b0); chk("R7 pulse ends", 32'(irq), 0);
    step(1'b1, 8'h04, 1'b0); chk("R4 cap4 fill", 32'(fill), 4);
    step(1'b1, 8'h05, 1'b0);
    chk("R10 full fill", 32'(fill), 4);
    chk("R10 full ovf", 32'(ovf), 1);
    // capacity 4, threshold code 000 -> level 1
    configure(16'h0007);
    step(1'b1, 8'h01, 1'b0); chk("R6 c4 k0 irq", 32'(irq), 1);
    // capacity 16, threshold code 111 -> full
    configure(16'h01CF);
    for (int j = 1; j <= 16; j++) begin
      step(1'b1, 8'(j), 1'b0);
      chk("R6 c16 k7 irq", 32'(irq), 32'(j == 16));
    end
    chk("R4 cap16 fill", 32'(fill), 16);

    // R8 every-message mode, capacity 4
    configure(16'h0027);
    step(1'b1, 8'h10, 1'b0); chk("R8 irq w1", 32'(irq), 1);
    step(1'b0, 8'h00, 1'b0); chk("R8 idle", 32'(irq), 0);
    step(1'b1, 8'h11, 1'b0); chk("R8 irq w2", 32'(irq), 1);
    step(1'b1, 8'h12, 1'b1);
    chk("R11 every-mode pair irq", 32'(irq), 1);
    chk("R11 every-mode pair fill", 32'(fill), 2);
    chk("R11 every-mode pair data", 32'(pop_data), 32'h10);

    // R9 interrupt enable off
    configure(16'h0025);
    step(1'b1, 8'h20, 1'b0);
    chk("R9 no irq", 32'(irq), 0);
    chk("R9 stored", 32'(fill), 1);

    // R4 storage disabled / zero capacity / reserved code
    configure(16'h0086);
    step(1'b1, 8'h30, 1'b0); chk("R4 disabled fill", 32'(fill), 0);
    step(1'b0, 8'h00, 1'b1); chk("R4 disabled pop", 32'(pop_valid), 0);
    configure(16'h0003);
    step(1'b1, 8'h31, 1'b0);
    chk("R4 code000 fill", 32'(fill), 0);
    chk("R4 code000 irq", 32'(irq), 0);
    configure(16'h0013);
    step(1'b1, 8'h32, 1'b0); chk("R4 code100 fill", 32'(fill), 0);

    finish_run();
  end
endmodule